// File: doc/BRIEF.md
# Phase-Synchronized Single-Channel PWM Generator

This block produces one pulse-width-modulated output from an up-counting time base. The counter runs from zero up to a programmable period value and then wraps back to zero. The output goes high when the counter is at zero and goes low when the counter matches a compare value. The duty cycle is therefore set by the compare value and the frequency by the period value. Software changes both through shadow registers. A new value reaches the active copy only when the counter is at zero, so a period that is already running is never cut short or stretched by a write.

Several channels can be chained so that they run with a fixed phase offset. A master channel sends a one-clock sync pulse each time its counter is at zero. A slave that has phase loading enabled jumps its counter to a programmed phase value when that pulse arrives. The slave can also pass the incoming pulse on to the next channel in the chain. For example, with a period of 1200, a slave phase value of 900 puts the slave 90 degrees behind the master. All configuration is written through a single-cycle write port with enable, address and data. The block also exports a strobe that is high while its counter is at zero.

Top module: `pwm_sync_chan`

## Requirements
- R1: The counter counts up by one each clock from 0 to the active period P and then returns to 0, so one output period lasts P+1 clocks.
- R2: A write to the period register (address 0) changes only the shadow copy. The active period takes the shadow value on the clock edge at which the counter is 0, so the period that is running keeps its old length.
- R3: A write to the compare register (address 1) changes only the shadow copy. The active compare takes the shadow value on the clock edge at which the counter is 0.
- R4: The output is registered. It is set on the edge where the counter is 0 and cleared on the edge where the counter equals the active compare C. For 1 ≤ C ≤ P it is high for exactly C clocks of every P+1.
- R5: When the counter is 0 and C is 0, the clear wins over the set, so C = 0 keeps the output low for the whole period. A compare above P keeps the output high all the time.
- R6: The control register is at address 3. Bit 0 is phase enable and bit 1 is the sync-out source. The phase register is at address 2. When phase enable is 1, a sync_in pulse loads the phase value into the counter on the next edge, and counting continues from that value.
- R7: When phase enable is 0, sync_in has no effect on the counter.
- R8: If a phase load and a wrap fall on the same edge (sync_in arrives while the counter equals P), the counter takes the phase value, not 0.
- R9: When control bit 1 is 0, sync_out is high while the counter is 0. When it is 1, sync_out follows sync_in in the same cycle.
- R10: zero_strobe is high exactly while the counter is 0.
- R11: After reset, the counter, all shadow and active registers, and the control bits are 0, and pwm_out is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register address: 0 period, 1 compare, 2 phase, 3 control |
| wr_data | input | CNT_W | Write data |
| sync_in | input | 1 | Single-cycle sync pulse from the upstream channel |
| pwm_out | output | 1 | PWM output |
| sync_out | output | 1 | Sync pulse to the downstream channel |
| zero_strobe | output | 1 | High while the counter is 0 |

## Verification
The duty-cycle function is driven with these period and compare pairs:
- a compare inside the period;
- a compare equal to the period;
- a compare of 1;
- a compare of 0;
- a compare above the period.

Together these separate a correct clear-over-set priority and correct match timing from off-by-one errors, and from a match stage that never fires or always fires.

The sync tests use:
- a pulse in the middle of a period, sent with phase loading on and again with it off;
- a pulse on the exact wrap cycle.

These show whether the load happens at all and whether it takes priority over the wrap. Writes made in the middle of a period show whether the shadowing of the period and compare holds until the next zero.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int unsigned REG_PRD   = 0;
  localparam int unsigned REG_CMP   = 1;
  localparam int unsigned REG_PHASE = 2;
  localparam int unsigned REG_CTRL  = 3;

  typedef enum logic {
    SYNC_AT_ZERO = 1'b0,
    SYNC_PASS    = 1'b1
  } sync_src_e;

  typedef struct packed {
    sync_src_e sync_src;
    logic      phase_en;
  } ctrl_t;
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic              at_zero,
  output logic [CNT_W-1:0]  act_prd,
  output logic [CNT_W-1:0]  act_cmp,
  output logic [CNT_W-1:0]  phase,
  output ctrl_t             ctrl
);
  logic [CNT_W-1:0] shd_prd_q, shd_prd_d;
  logic [CNT_W-1:0] shd_cmp_q, shd_cmp_d;
  logic [CNT_W-1:0] phase_q, phase_d;
  logic [CNT_W-1:0] act_prd_q, act_prd_d;
  logic [CNT_W-1:0] act_cmp_q, act_cmp_d;
  ctrl_t            ctrl_q, ctrl_d;

  always_comb begin
    shd_prd_d = shd_prd_q;
    shd_cmp_d = shd_cmp_q;
    phase_d   = phase_q;
    ctrl_d    = ctrl_q;
    if (wr_en) begin
      case (wr_addr)
        ADDR_W'(REG_PRD):   shd_prd_d = wr_data;
        ADDR_W'(REG_CMP):   shd_cmp_d = wr_data;
        ADDR_W'(REG_PHASE): phase_d   = wr_data;
        ADDR_W'(REG_CTRL): begin
          ctrl_d.phase_en = wr_data[0];
          ctrl_d.sync_src = sync_src_e'(wr_data[1]);
        end
        default: ;
      endcase
    end
  end

  // Active copies move only at counter zero.
  always_comb begin
    act_prd_d = act_prd_q;
    act_cmp_d = act_cmp_q;
    if (at_zero) begin
      act_prd_d = shd_prd_q;
      act_cmp_d = shd_cmp_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shd_prd_q <= '0;
      shd_cmp_q <= '0;
      phase_q   <= '0;
      ctrl_q    <= '0;
      act_prd_q <= '0;
      act_cmp_q <= '0;
    end else begin
      shd_prd_q <= shd_prd_d;
      shd_cmp_q <= shd_cmp_d;
      phase_q   <= phase_d;
      ctrl_q    <= ctrl_d;
      act_prd_q <= act_prd_d;
      act_cmp_q <= act_cmp_d;
    end
  end

  assign act_prd = act_prd_q;
  assign act_cmp = act_cmp_q;
  assign phase   = phase_q;
  assign ctrl    = ctrl_q;
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] act_prd,
  input  logic [CNT_W-1:0] phase,
  input  logic             phase_en,
  input  logic             sync_in,
  output logic [CNT_W-1:0] cnt,
  output logic             at_zero
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             sync_load;
  logic             wrap;

  assign sync_load = sync_in & phase_en;
  assign wrap      = (cnt_q >= act_prd);

  // Phase load has priority over the natural wrap.
  always_comb begin
    if (sync_load)
      cnt_d = phase;
    else if (wrap)
      cnt_d = '0;
    else
      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt     = cnt_q;
  assign at_zero = (cnt_q == '0);
endmodule

// File: rtl/pwm_action.sv
module pwm_action #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] act_cmp,
  input  logic             at_zero,
  output logic             pwm
);
  logic pwm_q, pwm_d;
  logic cmp_hit;

  assign cmp_hit = (cnt == act_cmp);

  // Clear on match wins over set at zero.
  always_comb begin
    pwm_d = pwm_q;
    if (cmp_hit)      pwm_d = 1'b0;
    else if (at_zero) pwm_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwm_q <= 1'b0;
    else        pwm_q <= pwm_d;
  end

  assign pwm = pwm_q;
endmodule

// File: rtl/pwm_sync_chan.sv
module pwm_sync_chan
  import pwm_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic              sync_in,
  output logic              pwm_out,
  output logic              sync_out,
  output logic              zero_strobe
);
  localparam int RST_STAGES = 2;

  logic [RST_STAGES-1:0] rst_pipe;
  logic                  rst_n_s;
  logic [CNT_W-1:0]      act_prd, act_cmp, phase, cnt;
  ctrl_t                 ctrl;
  logic                  at_zero;

  // Asynchronous assert, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[RST_STAGES-2:0], 1'b1};
  end
  assign rst_n_s = rst_pipe[RST_STAGES-1];

  pwm_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .at_zero (at_zero),
    .act_prd (act_prd),
    .act_cmp (act_cmp),
    .phase   (phase),
    .ctrl    (ctrl)
  );

  pwm_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .act_prd  (act_prd),
    .phase    (phase),
    .phase_en (ctrl.phase_en),
    .sync_in  (sync_in),
    .cnt      (cnt),
    .at_zero  (at_zero)
  );

  pwm_action #(.CNT_W(CNT_W)) u_act (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .cnt     (cnt),
    .act_cmp (act_cmp),
    .at_zero (at_zero),
    .pwm     (pwm_out)
  );

  assign sync_out    = (ctrl.sync_src == SYNC_PASS) ? sync_in : at_zero;
  assign zero_strobe = at_zero;
endmodule

// File: rtl/pwm_sync_chan_chk.sv
module pwm_sync_chan_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n_s,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] act_prd,
  input logic [CNT_W-1:0] act_cmp,
  input logic [CNT_W-1:0] phase,
  input logic             phase_en,
  input logic             sync_in,
  input logic             pwm_out
);
  AST_COUNT_UP: assert property (@(posedge clk) disable iff (!rst_n_s)
    (cnt < act_prd && !(sync_in && phase_en)) |=> cnt == CNT_W'($past(cnt) + 1'b1)); // R1

  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n_s)
    (cnt == act_prd && !(sync_in && phase_en)) |=> cnt == '0); // R1

  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n_s)
    (cnt != '0) |=> ($stable(act_prd) && $stable(act_cmp))); // R2

  AST_PWM_CLEAR: assert property (@(posedge clk) disable iff (!rst_n_s)
    (cnt == act_cmp) |=> !pwm_out); // R5

  AST_PWM_SET: assert property (@(posedge clk) disable iff (!rst_n_s)
    (cnt == '0 && act_cmp != '0) |=> pwm_out); // R4

  AST_PHASE_LOAD: assert property (@(posedge clk) disable iff (!rst_n_s)
    (sync_in && phase_en) |=> cnt == $past(phase)); // R8
endmodule

bind pwm_sync_chan pwm_sync_chan_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n_s  (rst_n_s),
  .cnt      (cnt),
  .act_prd  (act_prd),
  .act_cmp  (act_cmp),
  .phase    (phase),
  .phase_en (ctrl.phase_en),
  .sync_in  (sync_in),
  .pwm_out  (pwm_out)
);

// File: tb/pwm_sync_chan_tb.sv
module pwm_sync_chan_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 16;
  localparam int ADDR_W = 2;
  localparam int NVEC = 6;
  // period, compare, expected period length, expected high clocks
  localparam int VEC [NVEC][4] = '{
    '{9, 4, 10, 4},
    '{9, 0, 10, 0},
    '{9, 12, 10, 10},
    '{5, 5, 6, 5},
    '{15, 1, 16, 1},
    '{3, 2, 4, 2}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [CNT_W-1:0] wr_data;
  logic sync_in;
  logic pwm_out, sync_out, zero_strobe;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;

  pwm_sync_chan #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .sync_in(sync_in), .pwm_out(pwm_out),
    .sync_out(sync_out), .zero_strobe(zero_strobe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int addr, input int data);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = ADDR_W'(addr); wr_data = CNT_W'(data);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_zero();
    int guard = 0;
    @(negedge clk);
    while (!zero_strobe && guard < 1000) begin
      @(negedge clk); guard++;
    end
  endtask

  // Count clocks and high samples until the next zero.
  task automatic run_to_zero(output int len, output int hi);
    len = 0; hi = 0;
    do begin
      @(negedge clk);
      len++;
      if (pwm_out) hi++;
    end while (!zero_strobe && len < 1000);
  endtask

  // Pulse sync_in for one clock, count clocks until the next zero.
  task automatic sync_to_zero(output int n);
    sync_in = 1'b1;
    n = 0;
    do begin
      @(negedge clk);
      if (n == 0) sync_in = 1'b0;
      n++;
    end while (!zero_strobe && n < 1000);
  endtask

  initial begin
    int len, hi, n;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; sync_in = 1'b0;
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11 pwm low in reset", int'(pwm_out), 0);
    check("R10 zero strobe in reset", int'(zero_strobe), 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R11 pwm low after reset", int'(pwm_out), 0);
    check("R9 sync_out at zero, select 0", int'(sync_out), 1);

    // Table walk: R1 period length, R4/R5 duty
    for (int i = 0; i < NVEC; i++) begin
      wr(0, VEC[i][0]);
      wr(1, VEC[i][1]);
      wait_zero(); wait_zero();
      run_to_zero(len, hi);
      check($sformatf("R1 period len vec%0d", i), len, VEC[i][2]);
      check($sformatf("R4 R5 high clocks vec%0d", i), hi, VEC[i][3]);
    end

    // R2: period shadow
    wr(0, 9); wr(1, 4);
    wait_zero(); wait_zero();
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'd0; wr_data = 16'd5;
    run_to_zero(len, hi);
    wr_en = 1'b0;
    check("R2 old period kept", len, 9);
    run_to_zero(len, hi);
    check("R2 new period at zero", len, 6);

    // R3: compare shadow
    wr(0, 9);
    wait_zero(); wait_zero();
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'd1; wr_data = 16'd7;
    run_to_zero(len, hi);
    wr_en = 1'b0;
    check("R3 old compare kept", hi, 3);
    run_to_zero(len, hi);
    check("R3 new compare at zero", hi, 7);

    // R7: sync ignored with phase disabled
    wr(2, 7); wr(3, 0);
    wait_zero();
    repeat (2) @(negedge clk);
    sync_to_zero(n);
    check("R7 sync ignored", n, 8);

    // R6: sync loads phase, R9 pass-through
    wr(3, 3);
    wait_zero();
    check("R9 no sync_out at zero, select 1", int'(sync_out), 0);
    repeat (2) @(negedge clk);
    sync_in = 1'b1; #1;
    check("R9 sync_out follows sync_in", int'(sync_out), 1);
    sync_to_zero(n);
    check("R6 phase load", n, 4);

    // R8: sync on wrap cycle beats wrap
    wr(2, 4);
    wait_zero();
    repeat (9) @(negedge clk);
    check("R10 strobe low at count P", int'(zero_strobe), 0);
    sync_to_zero(n);
    check("R8 load beats wrap", n, 7);

    // R9: select 0 does not pass sync_in
    wr(3, 1);
    wait_zero();
    repeat (2) @(negedge clk);
    sync_in = 1'b1; #1;
    check("R9 select 0 ignores sync_in", int'(sync_out), 0);
    @(negedge clk);
    sync_in = 1'b0;

    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk); cyc++;
    end
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual %0d expected done", cyc);
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule